// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Sequencer

This block sits on the host side of a chain of identical 16-bit serial converters that share one conversion-start line and one serial clock line. The first converter's serial input is grounded and the last one's serial output returns to this block. A one-cycle start request, or an internal period timer in free-running mode, launches a sample: the conversion-start line rises while the serial clock is low. The block then waits a fixed number of system cycles to cover the slowest conversion, and issues one serial clock burst long enough to move every device's result out of the chain.

The serial clock comes from the system clock through a fixed divider. The incoming bit is captured on the clock's rising edge, since the converters change their output on the falling edge. The serial stream arrives with the device farthest down the chain first. The block stores each word in a slot for its physical position and, after the burst, streams the words out in chain order. Index 0 is the device whose serial input is grounded. The conversion-start line stays high from the rise until the last word has been delivered. It then drops, and it must stay low for an acquisition window before the next rise. Rises are also kept a minimum period apart.

Top module: `daisy_adc_seq`

## Requirements
- R1: After reset, `convst`, `sclk`, `busy`, `done` and `word_valid` are all low.
- R2: `sclk` is low at every rising edge of `convst`, and the first rising edge of `sclk` in a frame comes no earlier than CONV_WAIT_CYC system cycles after `convst` rises.
- R3: Each frame produces exactly WORD_W×N_DEV falling edges of `sclk`, and `sclk` is high only while `convst` is high.
- R4: After the burst, exactly N_DEV words are presented on consecutive cycles with `word_idx` counting 0 up to N_DEV−1. The word with index k is the value of the k-th device counted from the grounded end, assembled MSB first. Since the last device's word is received first, index N_DEV−1 holds the first WORD_W bits received.
- R5: `sdo_in` is captured in the system cycle in which `sclk` rises, so a bit that changes on a falling edge is read correctly.
- R6: A `start` pulse while `busy` is high is ignored: it neither adds a frame nor alters the frame in progress.
- R7: `convst` stays low for at least ACQ_CYC cycles before each rise, and two rises are at least MIN_PERIOD_CYC cycles apart. When a start arrives right after a short frame, the second rise lands exactly MIN_PERIOD_CYC cycles after the first.
- R8: With `free_run` high, frames repeat without `start`. The spacing between rises is `period_cyc`, or MIN_PERIOD_CYC if `period_cyc` is smaller. Clearing `free_run` stops new frames after the current one.
- R9: `done` pulses for one cycle, in the same cycle as the word with index N_DEV−1. In that cycle `busy` is already low, and `convst` falls on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a single frame |
| free_run | input | 1 | Repeat frames from the period timer |
| period_cyc | input | PER_W | Free-running rise spacing in system cycles |
| convst | output | 1 | Shared conversion-start line to all devices |
| sclk | output | 1 | Shared serial clock to all devices |
| sdo_in | input | 1 | Serial data from the last device in the chain |
| busy | output | 1 | A frame is armed or running |
| done | output | 1 | One-cycle end-of-frame pulse |
| word_valid | output | 1 | A result word is presented |
| word_idx | output | IDX_W | Chain position of the presented word, 0 at the grounded end |
| word_data | output | WORD_W | Result word |

## Verification
The hardest case to reach from the ports is the moment a start request meets both timing guards. The acquisition counter has to be satisfied and the period counter not yet, so the rise must wait for the period alone. The bench reaches it by issuing a start in the cycle after `done`, so the short frame leaves the period window still open. It then checks that the rise spacing equals the minimum period exactly. A bit-accurate model of three chained shift registers, which change on the falling edge, makes any capture on the wrong edge or any word-order slip show up as a data mismatch.

// File: rtl/daisy_adc_pkg.sv
package daisy_adc_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ARM,
        SEQ_CONV,
        SEQ_SHIFT,
        SEQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic sample;
        logic last;
    } shift_evt_t;

    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/daisy_adc_sclk.sv
module daisy_adc_sclk
    import daisy_adc_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 4,
    parameter int unsigned TOTAL_BITS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic       sclk,
    output shift_evt_t evt
);
    localparam int unsigned DIV_W = clog2_min1(2 * HALF_CYC);
    localparam int unsigned BIT_W = clog2_min1(TOTAL_BITS);
    localparam logic [DIV_W-1:0] RISE_AT = DIV_W'(HALF_CYC - 1);
    localparam logic [DIV_W-1:0] FALL_AT = DIV_W'(2 * HALF_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL_BITS - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            sclk_q  <= 1'b0;
        end else begin
            div_cnt <= (div_cnt == FALL_AT) ? '0 : div_cnt + DIV_W'(1);
            if (div_cnt == RISE_AT) begin
                sclk_q <= 1'b1;
            end
            if (div_cnt == FALL_AT) begin
                sclk_q  <= 1'b0;
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
        end
    end

    always_comb begin
        evt.sample = en && (div_cnt == RISE_AT);
        evt.last   = en && (div_cnt == FALL_AT) && (bit_cnt == LAST_BIT);
    end

    assign sclk = sclk_q;

    // R5: a capture strobe is always followed by a rising sclk
    a_r5_capture_at_rise: assert property (@(posedge clk) disable iff (rst)
        evt.sample |=> $rose(sclk_q));

endmodule

// File: rtl/daisy_adc_ctrl.sv
module daisy_adc_ctrl
    import daisy_adc_pkg::*;
#(
    parameter int unsigned CONV_WAIT_CYC  = 2200,
    parameter int unsigned ACQ_CYC        = 300,
    parameter int unsigned MIN_PERIOD_CYC = 2500,
    parameter int unsigned PER_W          = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             free_run,
    input  logic [PER_W-1:0] period_cyc,
    input  logic             last_fall,
    input  logic             drain_last,
    output seq_state_e       state,
    output logic             convst,
    output logic             busy,
    output logic             done
);
    localparam int unsigned WAIT_W = clog2_min1(CONV_WAIT_CYC);
    localparam int unsigned ACQ_W  = clog2_min1(ACQ_CYC + 1);
    localparam logic [PER_W-1:0]  MIN_P    = PER_W'(MIN_PERIOD_CYC);
    localparam logic [ACQ_W-1:0]  ACQ_FULL = ACQ_W'(ACQ_CYC);
    localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(CONV_WAIT_CYC - 1);

    seq_state_e        state_q;
    logic              convst_q;
    logic              done_q;
    logic [WAIT_W-1:0] wait_cnt;
    logic [ACQ_W-1:0]  acq_cnt;
    logic [PER_W-1:0]  since_rise;
    logic [PER_W-1:0]  eff_period;
    logic              acq_ok;
    logic              period_ok;
    logic              rise_evt;

    always_comb begin
        eff_period = (free_run && (period_cyc > MIN_P)) ? period_cyc : MIN_P;
        acq_ok     = (acq_cnt == ACQ_FULL);
        period_ok  = (since_rise >= eff_period);
        rise_evt   = (state_q == SEQ_ARM) && acq_ok && period_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            convst_q   <= 1'b0;
            done_q     <= 1'b0;
            wait_cnt   <= '0;
            acq_cnt    <= ACQ_FULL;
            since_rise <= '1;
        end else begin
            done_q <= 1'b0;

            if (rise_evt) begin
                since_rise <= PER_W'(1);
            end else if (since_rise != '1) begin
                since_rise <= since_rise + PER_W'(1);
            end

            if (convst_q) begin
                acq_cnt <= '0;
            end else if (!acq_ok) begin
                acq_cnt <= acq_cnt + ACQ_W'(1);
            end

            unique case (state_q)
                SEQ_IDLE: begin
                    if (start || free_run) begin
                        state_q <= SEQ_ARM;
                    end
                end
                SEQ_ARM: begin
                    if (rise_evt) begin
                        convst_q <= 1'b1;
                        wait_cnt <= '0;
                        state_q  <= SEQ_CONV;
                    end
                end
                SEQ_CONV: begin
                    if (wait_cnt == WAIT_END) begin
                        state_q <= SEQ_SHIFT;
                    end else begin
                        wait_cnt <= wait_cnt + WAIT_W'(1);
                    end
                end
                SEQ_SHIFT: begin
                    if (last_fall) begin
                        state_q <= SEQ_DRAIN;
                    end
                end
                SEQ_DRAIN: begin
                    if (drain_last) begin
                        convst_q <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign state  = state_q;
    assign convst = convst_q;
    assign busy   = (state_q != SEQ_IDLE);
    assign done   = done_q;

    // Independent observers of the conversion-start waveform
    logic [ACQ_W-1:0] lo_cnt;
    logic [PER_W-1:0] gap_cnt;
    logic             cv_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt  <= ACQ_FULL;
            gap_cnt <= '1;
            cv_d    <= 1'b0;
        end else begin
            cv_d <= convst_q;
            if (convst_q) begin
                lo_cnt <= '0;
            end else if (lo_cnt < ACQ_FULL) begin
                lo_cnt <= lo_cnt + ACQ_W'(1);
            end
            if (convst_q && !cv_d) begin
                gap_cnt <= PER_W'(1);
            end else if (gap_cnt != '1) begin
                gap_cnt <= gap_cnt + PER_W'(1);
            end
        end
    end

    a_r7_acq_window: assert property (@(posedge clk) disable iff (rst)
        $rose(convst_q) |-> (lo_cnt >= ACQ_FULL));

    a_r7_min_period: assert property (@(posedge clk) disable iff (rst)
        $rose(convst_q) |-> (gap_cnt >= MIN_P));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == SEQ_IDLE) && !convst_q);

endmodule

// File: rtl/daisy_adc_deser.sv
module daisy_adc_deser
    import daisy_adc_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned N_DEV  = 4,
    parameter int unsigned IDX_W  = clog2_min1(N_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  shift_evt_t        evt,
    input  logic              sdo_in,
    output logic              word_valid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_data,
    output logic              drain_last
);
    localparam int unsigned BIT_W = clog2_min1(WORD_W);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_DEV - 1);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_word;
    logic [BIT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  word_k;
    logic [IDX_W-1:0]  slot_sel;
    logic [WORD_W-1:0] slots [N_DEV];
    logic              emitting;
    logic [IDX_W-1:0]  emit_cnt;
    logic              out_valid;
    logic [IDX_W-1:0]  out_idx;
    logic [WORD_W-1:0] out_data;

    always_comb begin
        next_word  = {shreg[WORD_W-2:0], sdo_in};
        slot_sel   = IDX_END - word_k;
        drain_last = emitting && (emit_cnt == IDX_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            word_k    <= '0;
            emitting  <= 1'b0;
            emit_cnt  <= '0;
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_data  <= '0;
            for (int i = 0; i < int'(N_DEV); i++) begin
                slots[i] <= '0;
            end
        end else begin
            if (clear) begin
                bit_cnt <= '0;
                word_k  <= '0;
            end else if (evt.sample) begin
                shreg <= next_word;
                if (bit_cnt == BIT_END) begin
                    bit_cnt         <= '0;
                    slots[slot_sel] <= next_word;
                    word_k          <= word_k + IDX_W'(1);
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end

            if (evt.last) begin
                emitting <= 1'b1;
                emit_cnt <= '0;
            end else if (emitting) begin
                if (emit_cnt == IDX_END) begin
                    emitting <= 1'b0;
                end else begin
                    emit_cnt <= emit_cnt + IDX_W'(1);
                end
            end

            out_valid <= emitting;
            out_idx   <= emit_cnt;
            out_data  <= slots[emit_cnt];
        end
    end

    assign word_valid = out_valid;
    assign word_idx   = out_idx;
    assign word_data  = out_data;

    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_idx <= IDX_END));

    a_r4_idx_ascends: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_idx != IDX_END)) |=> out_valid && (out_idx == $past(out_idx) + IDX_W'(1)));

endmodule

// File: rtl/daisy_adc_seq.sv
module daisy_adc_seq
    import daisy_adc_pkg::*;
#(
    parameter int unsigned WORD_W         = 16,
    parameter int unsigned N_DEV          = 4,
    parameter int unsigned SCLK_HALF_CYC  = 4,
    parameter int unsigned CONV_WAIT_CYC  = 2200,
    parameter int unsigned ACQ_CYC        = 300,
    parameter int unsigned MIN_PERIOD_CYC = 2500,
    parameter int unsigned PER_W          = 16,
    parameter int unsigned IDX_W          = clog2_min1(N_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              free_run,
    input  logic [PER_W-1:0]  period_cyc,
    output logic              convst,
    output logic              sclk,
    input  logic              sdo_in,
    output logic              busy,
    output logic              done,
    output logic              word_valid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_data
);
    localparam int unsigned TOTAL_BITS = WORD_W * N_DEV;
    localparam int unsigned FALL_W     = clog2_min1(TOTAL_BITS + 1);

    seq_state_e state;
    shift_evt_t evt;
    logic       drain_last;

    daisy_adc_ctrl #(
        .CONV_WAIT_CYC  (CONV_WAIT_CYC),
        .ACQ_CYC        (ACQ_CYC),
        .MIN_PERIOD_CYC (MIN_PERIOD_CYC),
        .PER_W          (PER_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .free_run   (free_run),
        .period_cyc (period_cyc),
        .last_fall  (evt.last),
        .drain_last (drain_last),
        .state      (state),
        .convst     (convst),
        .busy       (busy),
        .done       (done)
    );

    daisy_adc_sclk #(
        .HALF_CYC   (SCLK_HALF_CYC),
        .TOTAL_BITS (TOTAL_BITS)
    ) u_sclk (
        .clk  (clk),
        .rst  (rst),
        .en   (state == SEQ_SHIFT),
        .sclk (sclk),
        .evt  (evt)
    );

    daisy_adc_deser #(
        .WORD_W (WORD_W),
        .N_DEV  (N_DEV),
        .IDX_W  (IDX_W)
    ) u_deser (
        .clk        (clk),
        .rst        (rst),
        .clear      (state == SEQ_CONV),
        .evt        (evt),
        .sdo_in     (sdo_in),
        .word_valid (word_valid),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .drain_last (drain_last)
    );

    // Port-level observers of the serial clock burst
    logic [FALL_W-1:0] fall_cnt;
    logic              sclk_d;
    logic              cv_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt <= '0;
            sclk_d   <= 1'b0;
            cv_d     <= 1'b0;
        end else begin
            sclk_d <= sclk;
            cv_d   <= convst;
            if (convst && !cv_d) begin
                fall_cnt <= '0;
            end else if (sclk_d && !sclk) begin
                fall_cnt <= fall_cnt + FALL_W'(1);
            end
        end
    end

    a_r2_sclk_low_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(convst) |-> !sclk);

    a_r3_sclk_inside_convst: assert property (@(posedge clk) disable iff (rst)
        sclk |-> convst);

    a_r3_no_extra_fall: assert property (@(posedge clk) disable iff (rst)
        (sclk_d && !sclk) |-> (fall_cnt < FALL_W'(TOTAL_BITS)));

    a_r3_full_burst: assert property (@(posedge clk) disable iff (rst)
        (cv_d && !convst) |-> (fall_cnt == FALL_W'(TOTAL_BITS)));

endmodule

// File: tb/daisy_adc_seq_bench.sv
`timescale 1ns/1ps
module daisy_adc_seq_bench;
    localparam int N     = 3;
    localparam int W     = 16;
    localparam int HALF  = 2;
    localparam int CW    = 40;
    localparam int ACQ   = 10;
    localparam int MINP  = 300;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             free_run = 1'b0;
    logic [PER_W-1:0] period_cyc = '0;
    logic             convst, sclk, sdo_in, busy, done, word_valid;
    logic [1:0]       word_idx;
    logic [W-1:0]     word_data;

    always #2 clk = ~clk;

    daisy_adc_seq #(
        .WORD_W (W), .N_DEV (N), .SCLK_HALF_CYC (HALF), .CONV_WAIT_CYC (CW),
        .ACQ_CYC (ACQ), .MIN_PERIOD_CYC (MINP), .PER_W (PER_W)
    ) u_daisy_adc_seq (
        .clk (clk), .rst (rst), .start (start), .free_run (free_run),
        .period_cyc (period_cyc), .convst (convst), .sclk (sclk),
        .sdo_in (sdo_in), .busy (busy), .done (done),
        .word_valid (word_valid), .word_idx (word_idx), .word_data (word_data)
    );

    // Chain model: device 0 has grounded input, device N-1 drives sdo_in
    logic [W-1:0] vals [N];
    logic [W-1:0] dev  [N];
    always @(posedge convst) begin
        for (int i = 0; i < N; i++) dev[i] <= vals[i];
    end
    always @(negedge sclk) begin
        dev[0] <= {dev[0][W-2:0], 1'b0};
        for (int i = 1; i < N; i++) dev[i] <= {dev[i][W-2:0], dev[i-1][W-1]};
    end
    assign sdo_in = dev[N-1][W-1];

    int checks = 0, fails = 0;
    int cyc = 0, rise_cyc = 0, last_period = 0, low_cnt = 1000000, last_low = 0;
    int falls = 0, frame_falls = 0, frames = 0, rises = 0, first_gap = 0;
    int rise_sclk_bad = 0, sclk_bad = 0, order_bad = 0, done_bad = 0, exp_idx = 0;
    bit seen_rise = 0, got_first = 0;
    logic p_cv = 0, p_sclk = 0;
    logic [W-1:0] got [N];

    always @(negedge clk) begin
        cyc++;
        if (convst && !p_cv) begin
            if (sclk) rise_sclk_bad++;
            if (seen_rise) last_period = cyc - rise_cyc;
            rise_cyc = cyc; seen_rise = 1; last_low = low_cnt;
            falls = 0; got_first = 0; rises++;
        end
        if (!convst) low_cnt++; else low_cnt = 0;
        if (sclk && !p_sclk) begin
            if (!convst) sclk_bad++;
            if (!got_first) begin first_gap = cyc - rise_cyc; got_first = 1; end
        end
        if (!sclk && p_sclk) falls++;
        if (!convst && p_cv) begin frame_falls = falls; frames++; end
        if (word_valid) begin
            if (int'(word_idx) != exp_idx) order_bad++;
            got[word_idx] = word_data;
            exp_idx = (exp_idx == N-1) ? 0 : exp_idx + 1;
        end
        if (done) begin
            if (!(word_valid && int'(word_idx) == N-1) || busy) done_bad++;
        end
        p_cv = convst; p_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset();
        chk(!convst && !sclk, "R1", "convst/sclk after reset", {convst, sclk}, 0);
        chk(!busy && !done && !word_valid, "R1", "busy/done/valid after reset",
            {busy, done, word_valid}, 0);
    endtask

    task automatic check_words(input string tag);
        for (int i = 0; i < N; i++)
            chk(got[i] === vals[i], "R4 R5", tag, int'(got[i]), int'(vals[i]));
    endtask

    task automatic t_frame(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c, input string tag);
        bit ok;
        vals[0] = a; vals[1] = b; vals[2] = c;
        for (int i = 0; i < N; i++) got[i] = '0;
        pulse_start();
        wait_done(ok);
        chk(ok, "R9", {tag, " done seen"}, ok, 1);
        @(negedge clk);
        check_words(tag);
        chk(order_bad == 0, "R4", "index order errors", order_bad, 0);
        chk(frame_falls == W*N, "R3", "sclk falling edges", frame_falls, W*N);
        chk(first_gap >= CW, "R2", "first sclk rise after convst", first_gap, CW);
        chk(rise_sclk_bad == 0 && sclk_bad == 0, "R2 R3", "sclk vs convst violations",
            rise_sclk_bad + sclk_bad, 0);
        chk(done_bad == 0 && !busy && !convst, "R9", "done alignment", done_bad, 0);
    endtask

    task automatic t_busy_start();
        bit ok;
        int f0;
        vals[0] = 16'h0A0A; vals[1] = 16'hC3C3; vals[2] = 16'h7E81;
        f0 = frames;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        wait_done(ok);
        repeat (2 * MINP) @(negedge clk);
        chk(frames == f0 + 1, "R6", "frames after starts while busy", frames - f0, 1);
        chk(!busy && !convst, "R6", "idle after ignored starts", busy, 0);
        check_words("R6 data intact");
    endtask

    task automatic t_min_period();
        bit ok;
        vals[0] = 16'h1111; vals[1] = 16'h2222; vals[2] = 16'h3333;
        pulse_start();
        wait_done(ok);
        pulse_start();
        wait_done(ok);
        @(negedge clk);
        chk(last_period == MINP, "R7", "back-to-back rise spacing", last_period, MINP);
        chk(last_low >= ACQ, "R7", "low time before rise", last_low, ACQ);
        check_words("R7 data");
    endtask

    task automatic wait_rises(input int n);
        int r0 = rises;
        for (int k = 0; k < 10000 && rises < r0 + n; k++) @(negedge clk);
    endtask

    task automatic t_free_run();
        int r0;
        vals[0] = 16'hDEAD; vals[1] = 16'hBEEF; vals[2] = 16'h0042;
        period_cyc = 16'd500;
        free_run = 1'b1;
        wait_rises(3);
        chk(last_period == 500, "R8", "free-run spacing", last_period, 500);
        period_cyc = 16'd100;
        wait_rises(3);
        chk(last_period == MINP, "R8", "free-run floor spacing", last_period, MINP);
        free_run = 1'b0;
        repeat (700) @(negedge clk);
        check_words("R8 data");
        r0 = rises;
        repeat (700) @(negedge clk);
        chk(rises == r0 && !busy, "R8", "rises after free_run cleared", rises - r0, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin vals[i] = '0; dev[i] = '0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(16'h1234, 16'hABCD, 16'h0F0F, "frame A");
        t_frame(16'hFFFF, 16'h0000, 16'h8001, "frame B");
        t_frame(16'h0001, 16'h8000, 16'h5555, "frame C");
        t_busy_start();
        t_min_period();
        t_free_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule